// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

The block gathers 64 level-sensitive request lines and tells a processor which pending source matters most. Line 63 is reserved and is never reported. Each line is gated by an enable bit. A per-line route bit sends it either to the normal request output or to the fast request output. Each output is the OR of the enabled, pending lines routed to it. For each output, a read-only register gives the 6-bit index of the winning line on that output.

Priority is positional: a lower index wins. A 32-bit error-class register can move any of lines 32 to 63 into an error class. A pending error-class line beats every normal-class line on the same output, including normal lines with a lower index. Among error-class lines, the lower index still wins. Software reaches the configuration and status through an APB slave that decodes word address bits [8:2].

Top module: `irq_prio_ctrl`

Register map (word index on `paddr[8:2]`, byte offset in brackets): 0 RAW_LO (0x00, RO), 1 RAW_HI (0x04, RO), 2 EN_LO (0x08, RW), 3 EN_HI (0x0C, RW), 4 ERRCLS (0x10, RW, bit k means line 32+k), 5 ROUTE_LO (0x14, RW), 6 ROUTE_HI (0x18, RW), 7 STAT_LO (0x1C, RO), 8 STAT_HI (0x20, RO), 9 NWIN (0x24, RO), 10 FWIN (0x28, RO). In the NWIN and FWIN words, bit 31 is a valid flag and bits [5:0] hold the line index.

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every configuration register reads 0, both request outputs are 0, and NWIN and FWIN read 0.
- R2: RAW_LO and RAW_HI return `irq_lines[31:0]` and `irq_lines[63:32]` as they stand during the read, with no delay.
- R3: STAT_LO and STAT_HI return the raw lines ANDed with EN_LO and EN_HI. Bit 31 of EN_HI (line 63) always reads 0 and ignores writes, so line 63 is never pending and never reported.
- R4: A line whose ROUTE bit is 1 drives only `irq_fast`, and a line whose ROUTE bit is 0 drives only `irq_norm`. Each output is the OR of the enabled, pending lines routed to it.
- R5: Within a class, the lowest pending index on an output wins. NWIN and FWIN read {valid at bit 31, zeros, index at [5:0]}.
- R6: ERRCLS bit k puts line 32+k into the error class. A pending, enabled error-class line on an output wins over all normal-class lines on that output, and among error-class lines the lowest index wins.
- R7: The request outputs and the NWIN/FWIN contents are registered. They reflect an input or configuration change at the first rising edge after the change, and not before.
- R8: NWIN or FWIN reads as all zeros when no enabled line is pending on that output.
- R9: Writes to RAW, STAT, NWIN or FWIN change no state, and reads of unmapped word indices (11 to 127) return 0.
- R10: A register is written only at a rising edge where `psel`, `penable` and `pwrite` are all 1. A setup phase alone, or an enable without a select, writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for APB and all state |
| rst_n | input | 1 | Synchronous active-low reset |
| paddr | input | 7 | APB word address, bits [8:2] |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (combinational) |
| irq_lines | input | 64 | Level-sensitive request lines, bit 63 reserved |
| irq_norm | output | 1 | Registered normal interrupt request |
| irq_fast | output | 1 | Registered fast interrupt request |

## Verification
Two things can change on the same edge: a configuration write and a change on the request lines. The bench lands an enable write's access phase on the same cycle in which it swaps `irq_lines`. It then expects the registered outputs and winner index, one edge later, to reflect both the new mask and the new lines together. The second overlap is an error-class request and a lower-indexed normal request pending at once. The bench judges both cases with its own priority model, and random line patterns and configurations keep producing this overlap.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and APB word addresses for the interrupt controller.
// Assumes a 64-line source bus split into two 32-bit register words.
package irqc_pkg;
    localparam int NL      = 64;              // request lines
    localparam int IW      = $clog2(NL);      // winner index width
    localparam int DW      = 32;              // APB data width
    localparam int AW      = 7;               // word address bits [8:2]
    localparam int HALF    = NL / 2;          // lines per register word
    localparam int RSV_BIT = NL - 1;          // reserved line

    localparam logic [AW-1:0] A_RAW_LO   = 7'd0;
    localparam logic [AW-1:0] A_RAW_HI   = 7'd1;
    localparam logic [AW-1:0] A_EN_LO    = 7'd2;
    localparam logic [AW-1:0] A_EN_HI    = 7'd3;
    localparam logic [AW-1:0] A_ERRCLS   = 7'd4;
    localparam logic [AW-1:0] A_ROUTE_LO = 7'd5;
    localparam logic [AW-1:0] A_ROUTE_HI = 7'd6;
    localparam logic [AW-1:0] A_STAT_LO  = 7'd7;
    localparam logic [AW-1:0] A_STAT_HI  = 7'd8;
    localparam logic [AW-1:0] A_NWIN     = 7'd9;
    localparam logic [AW-1:0] A_FWIN     = 7'd10;
endpackage

// File: rtl/irqc_enc.sv
// Module: lowest-index-first priority encoder.
// Assumes: purely combinational; idx is 0 when no request is present.
module irqc_enc #(
    parameter int N  = 64,
    parameter int XW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [XW-1:0] idx
);
    // Scan from the top so that the lowest set index is the last one kept.
    always_comb begin
        vld = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = XW'(i);
        end
    end
endmodule

// File: rtl/irqc_path.sv
// Module: one output path. Picks the error-class subset if it is non-empty,
// otherwise all routed requests, and registers the request and winner.
// Assumes: req is already masked by enable and route; errmask is 0 in the low half.
module irqc_path #(
    parameter int N  = 64,
    parameter int XW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  errmask,
    output logic          irq_q,
    output logic          vld_q,
    output logic [XW-1:0] idx_q
);
    logic [N-1:0]  err_req;
    logic [N-1:0]  pick;
    logic          enc_vld;
    logic [XW-1:0] enc_idx;

    assign err_req = req & errmask;
    assign pick    = (|err_req) ? err_req : req;

    irqc_enc #(.N(N), .XW(XW)) u_enc (
        .req (pick),
        .vld (enc_vld),
        .idx (enc_idx)
    );

    // Register the output request and the winning index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vld_q <= 1'b0;
            idx_q <= '0;
        end else begin
            irq_q <= |req;
            vld_q <= enc_vld;
            idx_q <= enc_idx;
        end
    end

    AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_req) |=> (vld_q && idx_q[XW-1])) else $error("error class lost"); // R6
    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> (irq_q && vld_q)) else $error("request not raised"); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req) |=> (!irq_q && !vld_q && idx_q == '0)) else $error("idle not zero"); // R8
endmodule

// File: rtl/irqc_regs.sv
// Module: APB register file and read mux for the interrupt controller.
// Assumes: zero-wait-state APB; writes commit at the edge of the access phase.
module irqc_regs
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] paddr,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    input  logic [NL-1:0] raw,
    input  logic [DW-1:0] nwin_word,
    input  logic [DW-1:0] fwin_word,
    output logic [NL-1:0] en,
    output logic [NL-1:0] route,
    output logic [NL-1:0] errmask
);
    localparam logic [DW-1:0] HI_KEEP = ~(DW'(1) << (RSV_BIT - HALF));

    logic [NL-1:0]   en_q;
    logic [NL-1:0]   route_q;
    logic [HALF-1:0] err_q;
    logic [NL-1:0]   stat;
    logic            wr;

    assign wr      = psel && penable && pwrite;
    assign stat    = raw & en_q;
    assign en      = en_q;
    assign route   = route_q;
    assign errmask = {err_q, {HALF{1'b0}}};

    // Commit APB writes to the writable registers; the reserved enable bit stays 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            err_q   <= '0;
        end else if (wr) begin
            case (paddr)
                A_EN_LO:    en_q[HALF-1:0]     <= pwdata;
                A_EN_HI:    en_q[NL-1:HALF]    <= pwdata & HI_KEEP;
                A_ERRCLS:   err_q              <= pwdata;
                A_ROUTE_LO: route_q[HALF-1:0]  <= pwdata;
                A_ROUTE_HI: route_q[NL-1:HALF] <= pwdata;
                default: ;
            endcase
        end
    end

    // Combinational read mux; unmapped addresses return 0.
    always_comb begin
        case (paddr)
            A_RAW_LO:   prdata = raw[HALF-1:0];
            A_RAW_HI:   prdata = raw[NL-1:HALF];
            A_EN_LO:    prdata = en_q[HALF-1:0];
            A_EN_HI:    prdata = en_q[NL-1:HALF];
            A_ERRCLS:   prdata = err_q;
            A_ROUTE_LO: prdata = route_q[HALF-1:0];
            A_ROUTE_HI: prdata = route_q[NL-1:HALF];
            A_STAT_LO:  prdata = stat[HALF-1:0];
            A_STAT_HI:  prdata = stat[NL-1:HALF];
            A_NWIN:     prdata = nwin_word;
            A_FWIN:     prdata = fwin_word;
            default:    prdata = '0;
        endcase
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(en_q) && $stable(route_q) && $stable(err_q))) else $error("config moved"); // R10
    AST_ERR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == A_ERRCLS) |=> (err_q == $past(pwdata))) else $error("errcls write lost"); // R6
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the two-class prioritized interrupt controller.
// Assumes: level-sensitive, already synchronous request lines; line 63 reserved.
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW+1:2]   paddr,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [DW-1:0]   pwdata,
    output logic [DW-1:0]   prdata,
    input  logic [NL-1:0]   irq_lines,
    output logic            irq_norm,
    output logic            irq_fast
);
    logic [NL-1:0]  en;
    logic [NL-1:0]  route;
    logic [NL-1:0]  errmask;
    logic [1:0]     o_irq;
    logic [1:0]     o_vld;
    logic [IW-1:0]  o_idx [2];
    logic [DW-1:0]  win_word [2];

    irqc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .paddr     (paddr),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .raw       (irq_lines),
        .nwin_word (win_word[0]),
        .fwin_word (win_word[1]),
        .en        (en),
        .route     (route),
        .errmask   (errmask)
    );

    // Path 0 serves the normal output (route bit 0), path 1 the fast output.
    for (genvar g = 0; g < 2; g++) begin : g_out
        logic [NL-1:0] req;
        assign req = irq_lines & en & ((g == 1) ? route : ~route);

        irqc_path #(.N(NL), .XW(IW)) u_path (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req),
            .errmask (errmask),
            .irq_q   (o_irq[g]),
            .vld_q   (o_vld[g]),
            .idx_q   (o_idx[g])
        );

        assign win_word[g] = {o_vld[g], {(DW - 1 - IW){1'b0}}, o_idx[g]};
    end

    assign irq_norm = o_irq[0];
    assign irq_fast = o_irq[1];

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld[0] && o_vld[1]) |-> (o_idx[0] != o_idx[1])) else $error("line on both outputs"); // R4
    AST_RSV_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld[0] || o_vld[1]) |-> ((!o_vld[0] || o_idx[0] != IW'(RSV_BIT)) &&
                                    (!o_vld[1] || o_idx[1] != IW'(RSV_BIT)))) else $error("reserved reported"); // R3
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:2]  paddr = '0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [63:0] irq_lines = '0;
    logic        irq_norm, irq_fast;

    int checks = 0, fails = 0;
    logic [63:0] m_en = '0, m_route = '0;
    logic [31:0] m_err = '0;

    always #10 clk = ~clk;   // 50 MHz

    irq_prio_ctrl u0 (.clk(clk), .rst_n(rst_n), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .irq_lines(irq_lines), .irq_norm(irq_norm), .irq_fast(irq_fast));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected winner word for one output: {valid, 25'b0, index}.
    function automatic logic [31:0] exp_win(input logic [63:0] raw, input bit fast);
        logic [63:0] req, e, pick;
        req  = raw & m_en & (fast ? m_route : ~m_route);
        e    = req & {m_err, 32'h0};
        pick = (e != 0) ? e : req;
        for (int i = 0; i < 64; i++)
            if (pick[i]) return {1'b1, 25'b0, 6'(i)};
        return 32'h0;
    endfunction

    function automatic logic exp_out(input logic [63:0] raw, input bit fast);
        return |(raw & m_en & (fast ? m_route : ~m_route));
    endfunction

    task automatic apb_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    // Write a configuration register and keep the bench model in step.
    task automatic cfg_wr(input logic [6:0] a, input logic [31:0] d);
        apb_wr(a, d);
        case (a)
            7'd2: m_en[31:0]     = d;
            7'd3: m_en[63:32]    = d & 32'h7FFF_FFFF;
            7'd4: m_err          = d;
            7'd5: m_route[31:0]  = d;
            7'd6: m_route[63:32] = d;
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        chk({tag, " irq_norm"}, 32'(irq_norm), 32'(exp_out(irq_lines, 0)));
        chk({tag, " irq_fast"}, 32'(irq_fast), 32'(exp_out(irq_lines, 1)));
        apb_rd(7'd9,  d); chk({tag, " NWIN"}, d, exp_win(irq_lines, 0));
        apb_rd(7'd10, d); chk({tag, " FWIN"}, d, exp_win(irq_lines, 1));
        apb_rd(7'd7,  d); chk("R3 STAT_LO", d, irq_lines[31:0] & m_en[31:0]);
        apb_rd(7'd8,  d); chk("R3 STAT_HI", d, irq_lines[63:32] & m_en[63:32]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_norm", 32'(irq_norm), 0);
        chk("R1 irq_fast", 32'(irq_fast), 0);
        for (int a = 2; a <= 6; a++) begin
            apb_rd(7'(a), d); chk("R1 config reg", d, 0);
        end
        apb_rd(7'd9, d); chk("R8 NWIN idle", d, 0);
        apb_rd(7'd10, d); chk("R8 FWIN idle", d, 0);

        // R2 raw reads follow the inputs
        irq_lines = 64'hA5A5_0F0F_1234_5678;
        apb_rd(7'd0, d); chk("R2 RAW_LO", d, 32'h1234_5678);
        apb_rd(7'd1, d); chk("R2 RAW_HI", d, 32'hA5A5_0F0F);

        // R3 reserved enable bit
        cfg_wr(7'd3, 32'hFFFF_FFFF);
        apb_rd(7'd3, d); chk("R3 EN_HI readback", d, 32'h7FFF_FFFF);
        irq_lines = 64'h8000_0000_0000_0000;
        @(negedge clk); @(negedge clk);
        chk("R3 line63 irq_norm", 32'(irq_norm), 0);
        apb_rd(7'd9, d); chk("R3 line63 NWIN", d, 0);
        apb_rd(7'd8, d); chk("R3 line63 STAT_HI", d, 0);

        // R9 writes to read-only addresses, unmapped reads
        cfg_wr(7'd2, 32'h0000_00F0);
        irq_lines = 64'h0000_0000_0000_0030;
        @(negedge clk);
        apb_wr(7'd7, 32'hFFFF_FFFF);
        apb_wr(7'd9, 32'hFFFF_FFFF);
        apb_wr(7'd0, 32'hFFFF_FFFF);
        apb_rd(7'd2, d); chk("R9 EN_LO unchanged", d, 32'h0000_00F0);
        apb_rd(7'd9, d); chk("R9 NWIN unchanged", d, 32'h8000_0004);
        apb_rd(7'd7, d); chk("R9 STAT_LO unchanged", d, 32'h0000_0030);
        apb_rd(7'd15, d); chk("R9 unmapped", d, 0);
        apb_rd(7'd127, d); chk("R9 unmapped top", d, 0);

        // R10 partial strobes write nothing
        @(negedge clk); psel = 1; pwrite = 1; paddr = 7'd2; pwdata = 32'hDEAD_BEEF; penable = 0;
        @(negedge clk); psel = 0; penable = 1;
        @(negedge clk); penable = 0; pwrite = 0;
        apb_rd(7'd2, d); chk("R10 EN_LO no write", d, 32'h0000_00F0);

        // R7 registered outputs: no change before the edge, change after
        cfg_wr(7'd2, 32'hFFFF_FFFF);
        irq_lines = 64'h0;
        @(negedge clk); @(negedge clk);
        irq_lines = 64'h0000_0000_0000_0100;
        #1 chk("R7 before edge", 32'(irq_norm), 0);
        @(negedge clk);
        chk("R7 after edge", 32'(irq_norm), 1);

        // R5 lower index wins; R6 error class
        cfg_wr(7'd3, 32'hFFFF_FFFF);
        irq_lines = 64'h0000_0001_0000_0001;   // lines 0 and 32
        @(negedge clk);
        check_all("R5 normal");
        cfg_wr(7'd4, 32'h0000_0001);            // line 32 error
        @(negedge clk);
        check_all("R6 error32");
        apb_rd(7'd9, d); chk("R6 error beats line0", d, 32'h8000_0020);
        cfg_wr(7'd4, 32'h0000_0108);            // lines 35 and 40 error
        irq_lines = 64'h0000_0108_0000_0008;    // lines 3, 35, 40
        @(negedge clk);
        apb_rd(7'd9, d); chk("R6 lowest error wins", d, 32'h8000_0023);

        // R4 routing
        cfg_wr(7'd6, 32'h0000_0008);            // line 35 to fast
        @(negedge clk);
        apb_rd(7'd10, d); chk("R4 FWIN line35", d, 32'h8000_0023);
        apb_rd(7'd9, d);  chk("R4 NWIN line40", d, 32'h8000_0028);
        check_all("R4 split");

        // Same cycle: enable write and input change land on one edge
        @(negedge clk); psel = 1; pwrite = 1; paddr = 7'd2; pwdata = 32'h0000_0004; penable = 0;
        @(negedge clk); penable = 1; irq_lines = 64'h0000_0000_0000_0006;
        m_en[31:0] = 32'h0000_0004; m_err = 32'h0000_0108;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        chk("R7 same-cycle irq_norm", 32'(irq_norm), 1);
        apb_rd(7'd9, d); chk("R5 same-cycle NWIN", d, 32'h8000_0002);

        // Random mix: R4 R5 R6 R8
        for (int it = 0; it < 250; it++) begin
            if (it % 5 == 0) cfg_wr(7'(2 + $urandom % 5), $urandom);
            irq_lines = (it % 3 == 0) ? ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom})
                                      : {$urandom, $urandom};
            @(negedge clk);
            check_all("R5 R6 random");
        end

        // R8 idle after everything cleared
        irq_lines = 64'h0;
        @(negedge clk); @(negedge clk);
        apb_rd(7'd9, d);  chk("R8 NWIN zero", d, 0);
        apb_rd(7'd10, d); chk("R8 FWIN zero", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule